// File: doc/BRIEF.md
# Transform Stage Scaling Unit

This block sits between the radix stages of a fixed-point transform datapath and rescales every complex sample passing from one stage to the next. A sample is a 32-bit word holding two signed 16-bit halves, in-phase above and quadrature below. A transform is started with a one-cycle start strobe that captures the configuration. The datapath then streams one frame per stage, and the last sample of each frame is marked.

Two scaling modes exist. In fixed mode software supplies a packed vector with one 3-bit right-shift field per stage, so each stage's data is scaled down by 0 to 4 bits. In block-floating mode the unit tracks the largest magnitude it emits during a frame and picks the shift for the next frame so that one bit of butterfly growth cannot overflow 16 bits. In both modes each shift rounds to nearest and saturates. After the final frame of the transform the unit pulses a done flag and reports the sum of all shifts applied, which is the block exponent of the result.

The transform length is chosen from 128 to 2048 points. A length of 2^n points runs n radix-2 stages, so n frames are scaled.

Top module: `stage_scaler`

## Requirements
- R1: `in_sample` bits 31:16 hold the signed in-phase part and bits 15:0 the signed quadrature part. Both halves are scaled independently with the same shift and return in the same positions of `out_sample`.
- R2: In fixed mode (`cfg_bfp`=0), frame k of the transform (k counted from 0) is shifted by the field `cfg_shift_vec[3k+2:3k]`. A field value of 5, 6 or 7 acts as 4. The shift stays constant over a frame and is shown on `out_shift` with every output sample.
- R3: A shift s>0 adds 2^(s-1) to the sign-extended value and then shifts it arithmetically right by s. A shift of 0 passes the value unchanged. The result is saturated to the signed 16-bit range.
- R4: Every accepted input sample appears on `out_sample` exactly one clock later, with `out_valid` high and `out_last` equal to the `in_last` it was accepted with.
- R5: `cfg_len_sel` codes 0..4 select 128..2048 points, that is 7 + code frames. Codes 5..7 act as 4 (2048 points, 11 frames).
- R6: In block-floating mode (`cfg_bfp`=1), frame 0 uses shift 0. Frame k>0 uses clamp(m + 1 - 15, 0, 4), where m is the bit length of the largest magnitude among all output halves of frame k-1. A negative value v counts as magnitude -v-1.
- R7: `xfm_done` is high for exactly one cycle, together with the output of the last sample of the last frame. In that cycle `xfm_exp` becomes the sum of the shifts of all frames, and it holds this value until the next done. Reset clears it to 0.
- R8: Input samples are dropped, with no output, when no transform is active, after the last frame has completed, and in the cycle `xfm_start` is high.
- R9: Mode, length and shift vector are captured only at `xfm_start`, and later changes to them have no effect. A start during a running transform abandons it and begins again at frame 0 with the new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfm_start | input | 1 | One-cycle strobe: capture configuration and begin a transform |
| cfg_bfp | input | 1 | 1 selects block-floating mode, 0 fixed per-stage shifts |
| cfg_len_sel | input | 3 | Transform length code, 2^(7+code) points |
| cfg_shift_vec | input | 33 | Eleven 3-bit fixed-mode shift fields, frame k in bits 3k+2:3k |
| in_valid | input | 1 | Input sample valid |
| in_sample | input | 32 | Input sample, I in 31:16, Q in 15:0 |
| in_last | input | 1 | Marks the last sample of a frame |
| out_valid | output | 1 | Output sample valid |
| out_sample | output | 32 | Scaled sample, same packing as input |
| out_last | output | 1 | Marks the last output sample of a frame |
| out_shift | output | 3 | Shift applied to the current output sample |
| xfm_done | output | 1 | One-cycle pulse at the final output sample of the transform |
| xfm_exp | output | 6 | Total shift of the last completed transform |

## Verification
The bench drives full-scale extremes through the 4-bit and 1-bit shifts, including -32768 and 32767. A wrong rounding offset or a logical instead of arithmetic shift would give an off-by-one or sign-flipped word there. Fixed-mode vectors carry out-of-range field values and length codes, so a missing clamp would show up as a wrong shift or a wrong number of frames before done. In block-floating mode each frame uses a random amplitude, which tests whether the peak from the previous frame, including its final sample, reaches the next frame's shift. A design that cleared the peak late or counted negatives as -v would choose a wrong shift. Configuration is changed right after start, and one transform is abandoned midway, which exposes designs that sample configuration live or fail to reset their frame count and exponent.

// File: rtl/ssu_pkg.sv
package ssu_pkg;

   typedef enum logic {
      SCALE_FIXED = 1'b0,
      SCALE_BFP   = 1'b1
   } scale_mode_e;

endpackage

// File: rtl/ssu_lane.sv
// One signed half of a complex sample: round-to-nearest right shift with saturation,
// plus the one's-complement magnitude of the result for peak tracking.
module ssu_lane #(
   parameter int W       = 16,
   parameter int SHIFT_W = 3
) (
   input  logic signed [W-1:0]   x_i,
   input  logic [SHIFT_W-1:0]    sh_i,
   output logic signed [W-1:0]   y_o,
   output logic [W-2:0]          mag_o
);
   localparam int EW = W + 1;
   localparam logic signed [EW-1:0] POS_LIM = {2'b00, {(W-1){1'b1}}};
   localparam logic signed [EW-1:0] NEG_LIM = {2'b11, {(W-1){1'b0}}};

   logic signed [EW-1:0] ext;
   logic signed [EW-1:0] bias;
   logic signed [EW-1:0] sum;
   logic signed [EW-1:0] shr;

   always_comb begin
      ext  = {x_i[W-1], x_i};
      bias = '0;
      for (int b = 0; b < EW - 1; b++) begin
         if (int'(sh_i) == b + 1) bias[b] = 1'b1;
      end
      sum = ext + bias;
      shr = sum >>> sh_i;
      if (shr > POS_LIM)      y_o = POS_LIM[W-1:0];
      else if (shr < NEG_LIM) y_o = NEG_LIM[W-1:0];
      else                    y_o = shr[W-1:0];
      mag_o = y_o[W-1] ? ~y_o[W-2:0] : y_o[W-2:0];
   end

endmodule

// File: rtl/ssu_peak.sv
// Tracks the OR of output magnitudes over a frame and, at its last sample,
// derives the shift for the following frame.
module ssu_peak #(
   parameter int W         = 16,
   parameter int SHIFT_W   = 3,
   parameter int MAX_SHIFT = 4,
   parameter int GROWTH    = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_i,
   input  logic               en_i,
   input  logic               last_i,
   input  logic [W-2:0]       mag_a_i,
   input  logic [W-2:0]       mag_b_i,
   output logic [SHIFT_W-1:0] shift_o
);
   localparam int MW = W - 1;

   logic [MW-1:0]      acc_q;
   logic [MW-1:0]      merged;
   int                 width_bits;
   int                 need;
   logic [SHIFT_W-1:0] next_sh;

   always_comb begin
      merged     = acc_q | mag_a_i | mag_b_i;
      width_bits = 0;
      for (int b = 0; b < MW; b++) begin
         if (merged[b]) width_bits = b + 1;
      end
      need = width_bits + GROWTH - MW;
      if (need < 0)              next_sh = '0;
      else if (need > MAX_SHIFT) next_sh = SHIFT_W'(MAX_SHIFT);
      else                       next_sh = SHIFT_W'(need);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         shift_o <= '0;
      end else if (clear_i) begin
         acc_q   <= '0;
         shift_o <= '0;
      end else if (en_i) begin
         if (last_i) begin
            acc_q   <= '0;
            shift_o <= next_sh;
         end else begin
            acc_q   <= merged;
         end
      end
   end

endmodule

// File: rtl/ssu_ctrl.sv
// Stage sequencing, configuration capture, shift selection and exponent sum.
module ssu_ctrl
   import ssu_pkg::*;
#(
   parameter int MAX_STAGES   = 11,
   parameter int MIN_LOG2_LEN = 7,
   parameter int NUM_LEN      = 5,
   parameter int SHIFT_W      = 3,
   parameter int MAX_SHIFT    = 4,
   parameter int EXP_W        = 6,
   parameter int LEN_W        = 3,
   localparam int VEC_W       = MAX_STAGES * SHIFT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               mode_i,
   input  logic [LEN_W-1:0]   len_sel_i,
   input  logic [VEC_W-1:0]   shift_vec_i,
   input  logic               in_valid_i,
   input  logic               in_last_i,
   input  logic [SHIFT_W-1:0] bfp_shift_i,
   output logic               run_o,
   output logic               accept_o,
   output logic [SHIFT_W-1:0] shift_o,
   output logic               done_o,
   output logic [EXP_W-1:0]   total_exp_o
);
   localparam int STG_W = $clog2(MAX_STAGES + 1);

   logic               run_q;
   logic [STG_W-1:0]   stage_q;
   logic [STG_W-1:0]   final_q;
   scale_mode_e        mode_q;
   logic [VEC_W-1:0]   vec_q;
   logic [EXP_W-1:0]   acc_q;
   logic [EXP_W-1:0]   total_q;
   logic               done_q;
   logic [SHIFT_W-1:0] fld;
   logic [SHIFT_W-1:0] fixed_sh;
   logic [LEN_W-1:0]   sel_c;
   logic               frame_end;
   logic               xfm_end;

   always_comb begin
      fld      = vec_q[int'(stage_q) * SHIFT_W +: SHIFT_W];
      fixed_sh = (fld > SHIFT_W'(MAX_SHIFT)) ? SHIFT_W'(MAX_SHIFT) : fld;
      shift_o  = (mode_q == SCALE_BFP) ? bfp_shift_i : fixed_sh;
      sel_c    = (len_sel_i > LEN_W'(NUM_LEN - 1)) ? LEN_W'(NUM_LEN - 1) : len_sel_i;
   end

   assign accept_o  = run_q & in_valid_i & ~start_i;
   assign frame_end = accept_o & in_last_i;
   assign xfm_end   = frame_end & (stage_q == final_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         stage_q <= '0;
         final_q <= '0;
         mode_q  <= SCALE_FIXED;
         vec_q   <= '0;
         acc_q   <= '0;
         total_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            run_q   <= 1'b1;
            stage_q <= '0;
            final_q <= STG_W'(MIN_LOG2_LEN) + STG_W'(sel_c) - STG_W'(1);
            mode_q  <= scale_mode_e'(mode_i);
            vec_q   <= shift_vec_i;
            acc_q   <= '0;
         end else if (frame_end) begin
            acc_q <= acc_q + EXP_W'(shift_o);
            if (xfm_end) begin
               run_q   <= 1'b0;
               done_q  <= 1'b1;
               total_q <= acc_q + EXP_W'(shift_o);
            end else begin
               stage_q <= stage_q + STG_W'(1);
            end
         end
      end
   end

   assign run_o       = run_q;
   assign done_o      = done_q;
   assign total_exp_o = total_q;

endmodule

// File: rtl/stage_scaler.sv
module stage_scaler #(
   parameter int HALF_W       = 16,
   parameter int SHIFT_W      = 3,
   parameter int MAX_SHIFT    = 4,
   parameter int MIN_LOG2_LEN = 7,
   parameter int NUM_LEN      = 5,
   parameter int GROWTH_BITS  = 1,
   parameter int LEN_W        = 3,
   localparam int SAMPLE_W    = 2 * HALF_W,
   localparam int MAX_STAGES  = MIN_LOG2_LEN + NUM_LEN - 1,
   localparam int VEC_W       = MAX_STAGES * SHIFT_W,
   localparam int EXP_W       = $clog2(MAX_STAGES * MAX_SHIFT + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                xfm_start,
   input  logic                cfg_bfp,
   input  logic [LEN_W-1:0]    cfg_len_sel,
   input  logic [VEC_W-1:0]    cfg_shift_vec,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_sample,
   input  logic                in_last,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_sample,
   output logic                out_last,
   output logic [SHIFT_W-1:0]  out_shift,
   output logic                xfm_done,
   output logic [EXP_W-1:0]    xfm_exp
);
   // elaboration-time parameter checks
   if (MAX_SHIFT >= HALF_W) begin : g_bad_shift
      $error("MAX_SHIFT must be below HALF_W");
   end
   if (MAX_SHIFT > (1 << SHIFT_W) - 1) begin : g_bad_shift_w
      $error("SHIFT_W too narrow for MAX_SHIFT");
   end
   if (GROWTH_BITS < 0 || GROWTH_BITS >= HALF_W) begin : g_bad_growth
      $error("GROWTH_BITS out of range");
   end
   if (NUM_LEN > (1 << LEN_W)) begin : g_bad_len
      $error("LEN_W too narrow for NUM_LEN");
   end

   logic                     run_w;
   logic                     accept_w;
   logic [SHIFT_W-1:0]       shift_w;
   logic [SHIFT_W-1:0]       bfp_shift_w;
   logic [SAMPLE_W-1:0]      scaled_w;
   logic [1:0][HALF_W-2:0]   mag_w;

   ssu_ctrl #(
      .MAX_STAGES  (MAX_STAGES),
      .MIN_LOG2_LEN(MIN_LOG2_LEN),
      .NUM_LEN     (NUM_LEN),
      .SHIFT_W     (SHIFT_W),
      .MAX_SHIFT   (MAX_SHIFT),
      .EXP_W       (EXP_W),
      .LEN_W       (LEN_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (xfm_start),
      .mode_i     (cfg_bfp),
      .len_sel_i  (cfg_len_sel),
      .shift_vec_i(cfg_shift_vec),
      .in_valid_i (in_valid),
      .in_last_i  (in_last),
      .bfp_shift_i(bfp_shift_w),
      .run_o      (run_w),
      .accept_o   (accept_w),
      .shift_o    (shift_w),
      .done_o     (xfm_done),
      .total_exp_o(xfm_exp)
   );

   // lane 1 = in-phase (upper half), lane 0 = quadrature (lower half)
   for (genvar g = 0; g < 2; g++) begin : g_lane
      logic signed [HALF_W-1:0] y_w;
      ssu_lane #(
         .W      (HALF_W),
         .SHIFT_W(SHIFT_W)
      ) u_lane (
         .x_i  (in_sample[g*HALF_W +: HALF_W]),
         .sh_i (shift_w),
         .y_o  (y_w),
         .mag_o(mag_w[g])
      );
      assign scaled_w[g*HALF_W +: HALF_W] = y_w;
   end

   ssu_peak #(
      .W        (HALF_W),
      .SHIFT_W  (SHIFT_W),
      .MAX_SHIFT(MAX_SHIFT),
      .GROWTH   (GROWTH_BITS)
   ) u_peak (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(xfm_start),
      .en_i   (accept_w),
      .last_i (in_last),
      .mag_a_i(mag_w[0]),
      .mag_b_i(mag_w[1]),
      .shift_o(bfp_shift_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
         out_last   <= 1'b0;
         out_shift  <= '0;
      end else begin
         out_valid <= accept_w;
         out_last  <= accept_w & in_last;
         if (accept_w) begin
            out_sample <= scaled_w;
            out_shift  <= shift_w;
         end
      end
   end

endmodule

// File: rtl/stage_scaler_chk.sv
module stage_scaler_chk #(
   parameter int SHIFT_W   = 3,
   parameter int MAX_SHIFT = 4,
   parameter int EXP_W     = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               xfm_start,
   input logic               in_valid,
   input logic               run,
   input logic               out_valid,
   input logic               out_last,
   input logic [SHIFT_W-1:0] out_shift,
   input logic               xfm_done,
   input logic [EXP_W-1:0]   xfm_exp
);

   p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && run && !xfm_start) |=> out_valid);

   p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid && run && !xfm_start));

   p_shift_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_shift <= SHIFT_W'(MAX_SHIFT)));

   p_shift_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) ##1 out_valid |-> $stable(out_shift));

   p_done_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      xfm_done |-> (out_valid && out_last));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      xfm_done |=> !xfm_done);

   p_exp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(xfm_exp) |-> xfm_done);

endmodule

bind stage_scaler stage_scaler_chk #(
   .SHIFT_W  (SHIFT_W),
   .MAX_SHIFT(MAX_SHIFT),
   .EXP_W    (EXP_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .xfm_start(xfm_start),
   .in_valid (in_valid),
   .run      (run_w),
   .out_valid(out_valid),
   .out_last (out_last),
   .out_shift(out_shift),
   .xfm_done (xfm_done),
   .xfm_exp  (xfm_exp)
);

// File: tb/tb_stage_scaler.sv
`timescale 1ns/1ps
module tb_stage_scaler;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfm_start = 1'b0;
   logic        cfg_bfp = 1'b0;
   logic [2:0]  cfg_len_sel = '0;
   logic [32:0] cfg_shift_vec = '0;
   logic        in_valid = 1'b0;
   logic [31:0] in_sample = '0;
   logic        in_last = 1'b0;
   logic        out_valid;
   logic [31:0] out_sample;
   logic        out_last;
   logic [2:0]  out_shift;
   logic        xfm_done;
   logic [5:0]  xfm_exp;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   int last_exp = 0;

   always #2.5 clk = ~clk;

   stage_scaler dut (
      .clk(clk), .rst_n(rst_n), .xfm_start(xfm_start), .cfg_bfp(cfg_bfp),
      .cfg_len_sel(cfg_len_sel), .cfg_shift_vec(cfg_shift_vec),
      .in_valid(in_valid), .in_sample(in_sample), .in_last(in_last),
      .out_valid(out_valid), .out_sample(out_sample), .out_last(out_last),
      .out_shift(out_shift), .xfm_done(xfm_done), .xfm_exp(xfm_exp)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int ref_scale(int x, int s);
      int y;
      if (s == 0) y = x;
      else        y = (x + (1 <<< (s - 1))) >>> s;
      if (y > 32767)  y = 32767;
      if (y < -32768) y = -32768;
      return y;
   endfunction

   function automatic int bitlen(int y);
      int m = (y < 0) ? -y - 1 : y;
      int n = 0;
      while (m > 0) begin n++; m = m >> 1; end
      return n;
   endfunction

   function automatic int rand_amp(int bits);
      return int'($urandom_range(0, (1 << (bits + 1)) - 1)) - (1 << bits);
   endfunction

   task automatic idle_probe(input int n);
      for (int i = 0; i < n; i++) begin
         in_valid  = 1'b1;
         in_sample = $urandom;
         in_last   = 1'b1;
         @(negedge clk);
         chk(out_valid == 1'b0, "R8", "idle out_valid", out_valid, 0);
         chk(xfm_done == 1'b0, "R8", "idle done", xfm_done, 0);
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   // amp_mode 1 injects full-scale corner samples at the head of each frame
   task automatic run_xfm(input bit bfp, input int len_sel, input logic [32:0] vec,
                          input int amp_mode, input int abort_after);
      int eff = (len_sel > 4) ? 4 : len_sel;
      int nst = 7 + eff;
      int n = 128 << eff;
      int exp_sum = 0;
      int prev_bits = 0;
      int count = 0;
      xfm_start     = 1'b1;
      cfg_bfp       = bfp;
      cfg_len_sel   = 3'(len_sel);
      cfg_shift_vec = vec;
      in_valid      = 1'b1;
      in_sample     = $urandom;
      @(negedge clk);
      chk(out_valid == 1'b0, "R8", "sample in start cycle", out_valid, 0);
      xfm_start     = 1'b0;
      cfg_bfp       = ~bfp;
      cfg_len_sel   = 3'($urandom);
      cfg_shift_vec = {$urandom, 1'b1};
      in_valid      = 1'b0;
      for (int k = 0; k < nst; k++) begin
         int sh;
         int peak = 0;
         int amp_bits = int'($urandom_range(0, 15));
         if (bfp) begin
            int need = prev_bits + 1 - 15;
            sh = (k == 0) ? 0 : ((need < 0) ? 0 : ((need > 4) ? 4 : need));
         end else begin
            sh = int'(vec[3*k +: 3]);
            if (sh > 4) sh = 4;
         end
         for (int i = 0; i < n; i++) begin
            int xi, xq, yi, yq;
            bit lst = (i == n - 1);
            bit fin = lst && (k == nst - 1);
            if ($urandom_range(0, 15) == 0) begin
               in_valid = 1'b0;
               @(negedge clk);
               chk(out_valid == 1'b0, "R8", "gap out_valid", out_valid, 0);
            end
            xi = rand_amp(amp_bits);
            xq = rand_amp(amp_bits);
            if (amp_mode == 1 && i == 0) begin xi = -32768; xq = 32767; end
            if (amp_mode == 1 && i == 1) begin xi = -1; xq = 1; end
            if (amp_mode == 1 && i == 2) begin xi = 32767; xq = -32768; end
            in_valid  = 1'b1;
            in_sample = {16'(xi), 16'(xq)};
            in_last   = lst;
            @(negedge clk);
            yi = ref_scale(xi, sh);
            yq = ref_scale(xq, sh);
            chk(out_valid == 1'b1, "R4", "out_valid", out_valid, 1);
            chk(out_sample == {16'(yi), 16'(yq)}, "R1 R3", "out_sample",
                out_sample, {16'(yi), 16'(yq)});
            chk(out_last == lst, "R4", "out_last", out_last, lst);
            chk(int'(out_shift) == sh, bfp ? "R6" : "R2", "out_shift", out_shift, sh);
            chk(xfm_done == fin, "R5 R7", "done", xfm_done, fin);
            if (fin) begin
               chk(int'(xfm_exp) == exp_sum + sh, "R7", "exponent", xfm_exp, exp_sum + sh);
               last_exp = exp_sum + sh;
            end else begin
               chk(int'(xfm_exp) == last_exp, "R7", "exponent hold", xfm_exp, last_exp);
            end
            if (bitlen(yi) > peak) peak = bitlen(yi);
            if (bitlen(yq) > peak) peak = bitlen(yq);
            count++;
            if (abort_after > 0 && count >= abort_after) begin
               in_valid = 1'b0;
               in_last  = 1'b0;
               return;
            end
         end
         exp_sum += sh;
         prev_bits = peak;
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   initial begin
      void'($urandom(32'h5C4A1E));
      repeat (4) @(negedge clk);
      chk(out_valid == 1'b0, "R4", "reset out_valid", out_valid, 0);
      chk(xfm_done == 1'b0, "R7", "reset done", xfm_done, 0);
      chk(xfm_exp == 6'd0, "R7", "reset exponent", xfm_exp, 0);
      rst_n = 1'b1;
      @(negedge clk);
      idle_probe(3);                                   // R8 before any start
      // R2 corners: fields 4, 7 (acts as 4), 1, 0, then random, length 128
      run_xfm(1'b0, 0, {21'h1A2B3C ^ 21'($urandom), 3'd0, 3'd1, 3'd7, 3'd4}, 1, 0);
      idle_probe(2);                                   // R8 after completion
      run_xfm(1'b1, 0, 33'h0, 1, 0);                   // R6 with corners
      run_xfm(1'b1, 3, 33'h0, 0, 0);                   // R6 longer
      run_xfm(1'b0, 7, {$urandom, 1'b0}, 0, 0);        // R5 code above 4 -> 2048 points
      run_xfm(1'b1, 1, 33'h0, 0, 300);                 // R9 abandoned midway
      run_xfm(1'b0, 1, {$urandom, 1'b1}, 1, 0);        // R9 restart from frame 0
      idle_probe(2);
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule